// File: doc/BRIEF.md
# Serial Addressed Control Register Bank for a Camera Analog Front-End

This block is the write-only control port of a camera analog front-end. A host sends 12-bit frames over three wires: an active-low frame enable, a serial clock and serial data. A faster system clock oversamples all three inputs. Each frame carries a 2-bit register select and a 10-bit payload. The frame is committed to one of four control registers when the enable line goes high again. The four registers are the ADC clamp level, the track/hold cut-off code, the amplifier gain and a set of pulse-polarity flags. Their contents are driven onto parallel outputs for the analog circuits.

The block also gates the 12-bit sample word coming from the converter. It forces that word to zero while standby is asserted. Two checks protect the settings. A frame that does not hold exactly 12 bits is dropped. A pending flag shows that the clamp level has changed and the gain has not yet been rewritten. The effective gain output stops at the top code of the usable gain range.

Top module: `afe_ctrl_port`

## Requirements
- R1: While reset is active and after it ends, the outputs show clamp 0, cut-off 0, gain 0, effective gain 0 and refresh-pending 0. The polarity outputs show sample pulses active high (samp_active_low=0), clamp pulses active high (clamp_active_high=1) and conversion on the rising edge (conv_on_rise=1).
- R2: A data bit is captured on each rising edge of ser_clk while ser_en_n is low. The first bit is the select MSB, then the select LSB, then payload bits 9 down to 0.
- R3: A frame takes effect on the third rising clk edge after the first clk edge that samples ser_en_n high. Before that edge the outputs keep their old values.
- R4: Select 00 writes all 10 payload bits to clamp_level.
- R5: Select 01 writes payload bits 3..0 to cutoff_code. Payload bits 9..4 are ignored.
- R6: Select 11 writes payload bit 0 to samp_active_low, bit 1 to clamp_active_high and bit 2 to conv_on_rise. Payload bits 9..3 are ignored.
- R7: Select 10 stores the 10-bit payload in gain_code. gain_eff equals gain_code when gain_code is below 767, and equals 767 otherwise.
- R8: A frame with fewer or more than 12 captured bits leaves every register unchanged. Serial clock edges while ser_en_n is high capture nothing.
- R9: refresh_pending is set by a clamp write and cleared by a gain write. Cut-off and polarity writes leave it unchanged.
- R10: While standby is 1, adc_word_out is 0. Otherwise adc_word_out equals adc_word_in, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_en_n | input | 1 | Frame enable, active low |
| ser_clk | input | 1 | Serial bit clock |
| ser_dat | input | 1 | Serial data |
| standby | input | 1 | Forces the sample output to zero |
| adc_word_in | input | 12 | Sample word from the converter |
| adc_word_out | output | 12 | Gated sample word |
| clamp_level | output | 10 | ADC clamp code |
| cutoff_code | output | 4 | Track/hold cut-off code |
| gain_code | output | 10 | Stored gain code |
| gain_eff | output | 10 | Gain code limited to 767 |
| samp_active_low | output | 1 | Sample pulses act on low level |
| clamp_active_high | output | 1 | Clamp pulses act on high level |
| conv_on_rise | output | 1 | Conversion on rising clock edge |
| refresh_pending | output | 1 | Clamp changed, gain not yet rewritten |

## Verification
Register outputs and refresh_pending change on the third clk edge after the edge that first samples ser_en_n high. gain_eff follows gain_code in the same cycle, and adc_word_out follows standby and adc_word_in at once. The reference model in the bench reproduces this behaviourally. It keeps a short history of the sampled pins, decides commits from the entries two and three edges old, and applies each commit one edge later. Every output is compared one time unit after each falling clk edge, so all design registers have settled. The bench also includes one directed check. It samples the old value after the third falling edge following enable release, and the new value after the fourth.

// File: rtl/afe_ctrl_pkg.sv
package afe_ctrl_pkg;

    localparam int ADR_W      = 2;
    localparam int PAY_W      = 10;
    localparam int FRAME_BITS = ADR_W + PAY_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam int CUT_W      = 4;
    localparam int POL_W      = 3;
    localparam int GAIN_TOP   = 767;
    localparam int SMP_W      = 12;

    typedef enum logic [ADR_W-1:0] {
        SEL_CLAMP  = 2'b00,
        SEL_CUTOFF = 2'b01,
        SEL_GAIN   = 2'b10,
        SEL_POLAR  = 2'b11
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e             sel;
        logic [PAY_W-1:0]     payload;
    } frame_t;

    typedef struct packed {
        logic conv_rise;
        logic clamp_high;
        logic samp_low;
    } polar_t;

    localparam polar_t POLAR_RST = '{conv_rise: 1'b1, clamp_high: 1'b1, samp_low: 1'b0};

    function automatic logic [PAY_W-1:0] cap_gain(input logic [PAY_W-1:0] g);
        if (int'(g) > GAIN_TOP)
            return PAY_W'(GAIN_TOP);
        return g;
    endfunction

endpackage

// File: rtl/afe_sync_edge.sv
module afe_sync_edge #(
    parameter int             N      = 3,
    parameter int             STAGES = 2,
    parameter logic [N-1:0]   IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              last;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {STAGES{IDLE[i]}};
                last  <= IDLE[i];
            end else begin
                chain <= {chain[STAGES-2:0], raw[i]};
                last  <= chain[STAGES-1];
            end
        end

        assign lvl[i]  = chain[STAGES-1];
        assign rise[i] = chain[STAGES-1] & ~last;
    end

endmodule

// File: rtl/afe_frame_rx.sv
module afe_frame_rx
    import afe_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en_lvl,
    input  logic   en_rise,
    input  logic   sck_rise,
    input  logic   dat_lvl,
    output logic   wr_vld,
    output frame_t wr_frame
);

    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            cnt      <= '0;
            wr_vld   <= 1'b0;
            wr_frame <= '0;
        end else begin
            wr_vld <= 1'b0;
            if (en_rise) begin
                if (cnt == CNT_W'(FRAME_BITS)) begin
                    wr_vld   <= 1'b1;
                    wr_frame <= frame_t'(shreg);
                end
                cnt <= '0;
            end else if (en_lvl) begin
                cnt <= '0;
            end else if (sck_rise) begin
                shreg <= {shreg[FRAME_BITS-2:0], dat_lvl};
                if (cnt != CNT_W'(FRAME_BITS + 1))
                    cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/afe_reg_bank.sv
module afe_reg_bank
    import afe_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_vld,
    input  frame_t           wr_frame,
    output logic [PAY_W-1:0] clamp_q,
    output logic [CUT_W-1:0] cutoff_q,
    output logic [PAY_W-1:0] gain_q,
    output polar_t           polar_q,
    output logic             refresh_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            clamp_q   <= '0;
            cutoff_q  <= '0;
            gain_q    <= '0;
            polar_q   <= POLAR_RST;
            refresh_q <= 1'b0;
        end else if (wr_vld) begin
            unique case (wr_frame.sel)
                SEL_CLAMP: begin
                    clamp_q   <= wr_frame.payload;
                    refresh_q <= 1'b1;
                end
                SEL_CUTOFF: cutoff_q <= wr_frame.payload[CUT_W-1:0];
                SEL_GAIN: begin
                    gain_q    <= wr_frame.payload;
                    refresh_q <= 1'b0;
                end
                SEL_POLAR: polar_q <= polar_t'(wr_frame.payload[POL_W-1:0]);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/afe_ctrl_port.sv
module afe_ctrl_port
    import afe_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_en_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             standby,
    input  logic [SMP_W-1:0] adc_word_in,
    output logic [SMP_W-1:0] adc_word_out,
    output logic [PAY_W-1:0] clamp_level,
    output logic [CUT_W-1:0] cutoff_code,
    output logic [PAY_W-1:0] gain_code,
    output logic [PAY_W-1:0] gain_eff,
    output logic             samp_active_low,
    output logic             clamp_active_high,
    output logic             conv_on_rise,
    output logic             refresh_pending
);

    localparam int SYNC_N = 3;
    localparam logic [SYNC_N-1:0] SYNC_IDLE = 3'b100;

    logic [SYNC_N-1:0] pin_raw, pin_lvl, pin_rise;
    logic              wr_vld;
    frame_t            wr_frame;
    polar_t            polar_q;

    assign pin_raw = {ser_en_n, ser_clk, ser_dat};

    afe_sync_edge #(.N(SYNC_N), .STAGES(2), .IDLE(SYNC_IDLE)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (pin_raw),
        .lvl  (pin_lvl),
        .rise (pin_rise)
    );

    afe_frame_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .en_lvl   (pin_lvl[2]),
        .en_rise  (pin_rise[2]),
        .sck_rise (pin_rise[1]),
        .dat_lvl  (pin_lvl[0]),
        .wr_vld   (wr_vld),
        .wr_frame (wr_frame)
    );

    afe_reg_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_vld    (wr_vld),
        .wr_frame  (wr_frame),
        .clamp_q   (clamp_level),
        .cutoff_q  (cutoff_code),
        .gain_q    (gain_code),
        .polar_q   (polar_q),
        .refresh_q (refresh_pending)
    );

    assign gain_eff          = cap_gain(gain_code);
    assign samp_active_low   = polar_q.samp_low;
    assign clamp_active_high = polar_q.clamp_high;
    assign conv_on_rise      = polar_q.conv_rise;
    assign adc_word_out      = standby ? '0 : adc_word_in;

endmodule

// File: rtl/afe_ctrl_chk.sv
module afe_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_vld,
    input logic [1:0] wr_sel,
    input logic [9:0] wr_payload,
    input logic [9:0] clamp_level,
    input logic [3:0] cutoff_code,
    input logic [9:0] gain_code,
    input logic [9:0] gain_eff,
    input logic       samp_active_low,
    input logic       clamp_active_high,
    input logic       conv_on_rise,
    input logic       refresh_pending
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (clamp_level == 10'd0 && cutoff_code == 4'd0 && gain_code == 10'd0
                 && !samp_active_low && clamp_active_high && conv_on_rise && !refresh_pending)); // R1

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_vld |=> ($stable(clamp_level) && $stable(cutoff_code) && $stable(gain_code)
                     && $stable(refresh_pending))); // R8

    AST_CUTOFF_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        (wr_vld && wr_sel == 2'b01) |=> cutoff_code == $past(wr_payload[3:0])); // R5

    AST_REFRESH_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_vld && wr_sel == 2'b00) |=> refresh_pending); // R9

    AST_REFRESH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_vld && wr_sel == 2'b10) |=> !refresh_pending); // R9

    AST_GAIN_EFF_STABLE: assert property (@(posedge clk) disable iff (rst)
        $stable(gain_code) |-> $stable(gain_eff)); // R7

endmodule

bind afe_ctrl_port afe_ctrl_chk u_chk (
    .clk               (clk),
    .rst               (rst),
    .wr_vld            (wr_vld),
    .wr_sel            (wr_frame.sel),
    .wr_payload        (wr_frame.payload),
    .clamp_level       (clamp_level),
    .cutoff_code       (cutoff_code),
    .gain_code         (gain_code),
    .gain_eff          (gain_eff),
    .samp_active_low   (samp_active_low),
    .clamp_active_high (clamp_active_high),
    .conv_on_rise      (conv_on_rise),
    .refresh_pending   (refresh_pending)
);

// File: tb/tb_afe_ctrl_port.sv
module tb_afe_ctrl_port;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_n = 1'b1, sck = 1'b0, dat = 1'b0, stby = 1'b0;
    logic [11:0] ain = 12'h000;
    logic [11:0] aout;
    logic [9:0]  clamp, gain, geff;
    logic [3:0]  cut;
    logic        slow, chigh, crise, refr;

    int compared = 0;
    int mismatched = 0;

    afe_ctrl_port dut (
        .clk(clk), .rst(rst), .ser_en_n(en_n), .ser_clk(sck), .ser_dat(dat),
        .standby(stby), .adc_word_in(ain), .adc_word_out(aout),
        .clamp_level(clamp), .cutoff_code(cut), .gain_code(gain), .gain_eff(geff),
        .samp_active_low(slow), .clamp_active_high(chigh), .conv_on_rise(crise),
        .refresh_pending(refr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int          m_clamp, m_cut, m_gain, m_refr, m_cnt;
    logic [2:0]  m_pol;          // {conv_rise, clamp_high, samp_low}
    logic [11:0] m_sh, m_pw;
    bit          m_pend;
    logic [2:0]  hist [$];       // sampled {en, sck, dat}, newest at front

    always @(posedge clk) begin
        if (rst) begin
            m_clamp = 0; m_cut = 0; m_gain = 0; m_refr = 0; m_cnt = 0;
            m_pol = 3'b110; m_sh = '0; m_pend = 0;
            hist = '{3'b100, 3'b100, 3'b100};
        end else begin
            if (m_pend) begin
                case (m_pw[11:10])
                    2'b00: begin m_clamp = int'(m_pw[9:0]); m_refr = 1; end
                    2'b01: m_cut = int'(m_pw[3:0]);
                    2'b10: begin m_gain = int'(m_pw[9:0]); m_refr = 0; end
                    default: m_pol = m_pw[2:0];
                endcase
            end
            m_pend = 0;
            if (hist[1][2] && !hist[2][2]) begin
                if (m_cnt == 12) begin m_pend = 1; m_pw = m_sh; end
                m_cnt = 0;
            end else if (hist[1][2]) begin
                m_cnt = 0;
            end else if (hist[1][1] && !hist[2][1]) begin
                m_sh = {m_sh[10:0], hist[1][0]};
                m_cnt++;
            end
            hist.push_front({en_n, sck, dat});
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        #1;
        if (!rst) begin
            chk("R4 clamp_level", int'(clamp), m_clamp);
            chk("R5 cutoff_code", int'(cut), m_cut);
            chk("R7 gain_code", int'(gain), m_gain);
            chk("R7 gain_eff", int'(geff), (m_gain > 767) ? 767 : m_gain);
            chk("R6 polarity", int'({crise, chigh, slow}), int'(m_pol));
            chk("R9 refresh_pending", int'(refr), m_refr);
            chk("R10 adc_word_out", int'(aout), stby ? 0 : int'(ain));
        end
    end

    task automatic shift_bits(input int nbits, input logic [15:0] word);
        @(negedge clk) en_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            dat = word[i];
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send(input int nbits, input logic [15:0] word);
        shift_bits(nbits, word);
        en_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [9:0] pay);
        send(12, {4'b0, sel, pay});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset clamp", int'(clamp), 0);
        chk("R1 reset polarity", int'({crise, chigh, slow}), 6);
        chk("R1 reset refresh", int'(refr), 0);
        @(negedge clk) rst = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        chk("R1 after reset gain_eff", int'(geff), 0);
        chk("R1 after reset cutoff", int'(cut), 0);

        wr(2'b00, 10'h2A5);
        #1;
        chk("R2 R4 clamp bit order", int'(clamp), 'h2A5);
        chk("R9 refresh set by clamp", int'(refr), 1);

        wr(2'b01, 10'h3F6);
        #1;
        chk("R5 cutoff low bits", int'(cut), 6);
        chk("R9 refresh kept by cutoff", int'(refr), 1);

        wr(2'b11, 10'h3F9);
        #1;
        chk("R6 polarity bits", int'({crise, chigh, slow}), 1);
        chk("R9 refresh kept by polarity", int'(refr), 1);

        wr(2'b10, 10'd500);
        #1;
        chk("R7 gain 500", int'(geff), 500);
        chk("R9 refresh cleared by gain", int'(refr), 0);

        wr(2'b10, 10'd1023);
        #1 chk("R7 gain 1023 capped", int'(geff), 767);
        wr(2'b10, 10'd767);
        #1 chk("R7 gain 767", int'(geff), 767);
        wr(2'b10, 10'd766);
        #1 chk("R7 gain 766", int'(geff), 766);

        send(11, 16'h0155);
        #1 chk("R8 short frame ignored", int'(clamp), 'h2A5);
        send(13, 16'h0111);
        #1 chk("R8 long frame ignored", int'(clamp), 'h2A5);
        chk("R8 long frame refresh", int'(refr), 0);

        // serial clock pulses with enable high capture nothing
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) sck = 1'b1; dat = i[0];
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        wr(2'b00, 10'h0F0);
        #1 chk("R8 idle clocks ignored", int'(clamp), 'h0F0);

        // commit timing
        shift_bits(12, {4'b0, 2'b00, 10'h11C});
        en_n = 1'b1;
        repeat (3) @(negedge clk);
        #1 chk("R3 old value before third edge", int'(clamp), 'h0F0);
        @(negedge clk);
        #1 chk("R3 new value at third edge", int'(clamp), 'h11C);

        // standby gating
        @(negedge clk) ain = 12'hABC; stby = 1'b0;
        #1 chk("R10 pass through", int'(aout), 'hABC);
        @(negedge clk) stby = 1'b1;
        #1 chk("R10 standby zero", int'(aout), 0);
        @(negedge clk) ain = 12'hFFF;
        #1 chk("R10 standby all ones in", int'(aout), 0);
        @(negedge clk) stby = 1'b0;
        #1 chk("R10 release", int'(aout), 'hFFF);
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule